// File: doc/BRIEF.md
# Serial Converter Frame Readout Master

This block is the host side of a 16-clock serial link to a four-channel successive-approximation converter. When `start` is accepted, it pulls the chip-select low and generates sixteen serial-clock periods from the system clock. During those periods it shifts a 12-bit control word out, MSB first, followed by four zero bits. In the same periods it shifts the converter's 16-bit response in. The serial clock rests high between frames. Each half-period of the serial clock lasts `HALF_DIV` system-clock cycles.

The response frame has a fixed layout, MSB first. It starts with two bits that must be zero, then a 2-bit channel tag, then the conversion result left-aligned in the remaining twelve positions. The result is `RES_BITS` wide (8, 10 or 12), and any trailing padding is discarded. At the end of a frame the block registers the channel tag and the right-justified result, and raises a one-cycle valid strobe. It also flags an error when either leading bit was not zero.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, `cs_n` and `sclk` are high, `mosi`, `res_valid` and `busy` are low.
- R2: An accepted frame holds `cs_n` low for exactly 16 falling `sclk` edges. Each `sclk` half-period is `HALF_DIV` clock cycles. `res_valid` rises 33*`HALF_DIV` clock cycles after the edge that accepted `start`, together with `cs_n` returning high.
- R3: `mosi` changes only at the cycle that loads a frame and at rising `sclk` edges. At falling edges 1 to 12 it carries `ctrl_word` bit 11 down to bit 0. At falling edges 13 to 16 it is 0.
- R4: `miso` is sampled at each of the 16 falling `sclk` edges. The first sample is the bit present since `cs_n` fell. Samples fill the response word from bit 15 down to bit 0.
- R5: `res_chan` is response bits 13:12 (bit 13 is the tag MSB).
- R6: `res_data` is response bits 11 down to 12-`RES_BITS`, right-justified. Response bits below that are ignored.
- R7: `frame_err` is 1 when response bit 15 or bit 14 is 1, and 0 otherwise. It is updated with each result.
- R8: `res_valid` is high for exactly one clock per frame. `res_chan`, `res_data` and `frame_err` hold their values until the next strobe.
- R9: `start` is ignored while `busy` is high, including the inter-frame gap. Such a pulse starts no frame and changes no transmitted bit.
- R10: `sclk` is high whenever `cs_n` is high. Between two frames `cs_n` stays high for at least 2*`HALF_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame; accepted only when idle |
| ctrl_word | input | 12 | Control word sent at the start of the frame, MSB first |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip-select framing the transfer |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_chan | output | 2 | Channel tag of the last result |
| res_data | output | RES_BITS | Right-justified conversion result |
| frame_err | output | 1 | A leading response bit was nonzero |

## Verification
The bench sweeps every 8-bit result value on all four channels, with the padding bits alternately all-ones and zeros. A design that kept the padding, or that sampled one edge late or early, would return shifted data or corrupted tags. It drives responses with each leading bit set on its own. Only the chip-select edge presents the first of those bits, so a design that skips the initial sample would miss the error. A peripheral model records `mosi` at every falling edge to catch an off-by-one control word or nonzero tail bits. Further tests send `start` pulses in mid-frame and in the gap, and hold `start` high across back-to-back frames. These catch a design that restarts, corrupts the control word or shortens the chip-select high time.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    localparam int FRAME_LEN = 16;
    localparam int CTRL_LEN  = 12;
    localparam int BODY_LEN  = FRAME_LEN - 4;
    localparam int EDGE_W    = $clog2(FRAME_LEN + 1);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_LOW,
        SQ_HIGH,
        SQ_GAP
    } seq_state_t;

    typedef struct packed {
        logic                lead_err;
        logic [1:0]          chan;
        logic [BODY_LEN-1:0] body;
    } frame_fields_t;

    function automatic frame_fields_t split_frame(input logic [FRAME_LEN-1:0] w);
        frame_fields_t f;
        f.lead_err = w[FRAME_LEN-1] | w[FRAME_LEN-2];
        f.chan     = w[FRAME_LEN-3 -: 2];
        f.body     = w[BODY_LEN-1:0];
        return f;
    endfunction

endpackage

// File: rtl/afm_clkdiv.sv
module afm_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    a_r2_half_period_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/afm_sequencer.sv
module afm_sequencer
    import adc_frame_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic run,
    output logic sclk,
    output logic cs_n,
    output logic load,
    output logic rise,
    output logic fall,
    output logic done
);
    seq_state_t        state;
    logic [EDGE_W-1:0] edges;
    logic              gap_half;
    logic              last_edge;

    assign last_edge = (edges == EDGE_W'(FRAME_LEN));

    always_comb begin
        run  = (state != SQ_IDLE);
        load = (state == SQ_IDLE) && start;
        fall = tick && ((state == SQ_SETUP) || ((state == SQ_HIGH) && !last_edge));
        rise = tick && (state == SQ_LOW);
        done = tick && (state == SQ_HIGH) && last_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            sclk     <= 1'b1;
            cs_n     <= 1'b1;
            edges    <= '0;
            gap_half <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cs_n  <= 1'b0;
                        edges <= '0;
                        state <= SQ_SETUP;
                    end
                end
                SQ_SETUP: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        edges <= edges + 1'b1;
                        state <= SQ_LOW;
                    end
                end
                SQ_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= SQ_HIGH;
                    end
                end
                SQ_HIGH: begin
                    if (tick) begin
                        if (last_edge) begin
                            cs_n     <= 1'b1;
                            gap_half <= 1'b0;
                            state    <= SQ_GAP;
                        end else begin
                            sclk  <= 1'b0;
                            edges <= edges + 1'b1;
                            state <= SQ_LOW;
                        end
                    end
                end
                SQ_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= SQ_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    a_r10_sclk_high_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    a_r2_edge_count_bound: assert property (@(posedge clk) disable iff (rst)
        edges <= EDGE_W'(FRAME_LEN));

    a_r2_select_held_until_done: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !done) |=> !cs_n);

    a_r9_no_restart_in_frame: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LOW || state == SQ_HIGH || state == SQ_GAP) |=> (state != SQ_SETUP));

endmodule

// File: rtl/afm_shifter.sv
module afm_shifter
    import adc_frame_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CTRL_LEN-1:0]  ctrl,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 miso,
    output logic                 mosi,
    output logic [FRAME_LEN-1:0] rx_word
);
    localparam int TAIL = FRAME_LEN - CTRL_LEN;

    logic [FRAME_LEN-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= {ctrl, {TAIL{1'b0}}};
        end else if (rise) begin
            tx_sr <= {tx_sr[FRAME_LEN-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
        end else if (fall) begin
            rx_word <= {rx_word[FRAME_LEN-2:0], miso};
        end
    end

    assign mosi = tx_sr[FRAME_LEN-1];

    a_r3_mosi_moves_on_rise_only: assert property (@(posedge clk) disable iff (rst)
        (!rise && !load) |=> $stable(mosi));

    a_r4_capture_on_fall_only: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(rx_word));

endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
    import adc_frame_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [11:0]         ctrl_word,
    input  logic                miso,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    output logic                busy,
    output logic                res_valid,
    output logic [1:0]          res_chan,
    output logic [RES_BITS-1:0] res_data,
    output logic                frame_err
);
    localparam int PAD = BODY_LEN - RES_BITS;

    logic                 run_w, tick_w, load_w, rise_w, fall_w, done_w;
    logic [FRAME_LEN-1:0] rx_w;
    frame_fields_t        fields;

    afm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .tick (tick_w)
    );

    afm_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick_w),
        .run   (run_w),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .load  (load_w),
        .rise  (rise_w),
        .fall  (fall_w),
        .done  (done_w)
    );

    afm_shifter u_shf (
        .clk     (clk),
        .rst     (rst),
        .load    (load_w),
        .ctrl    (ctrl_word),
        .rise    (rise_w),
        .fall    (fall_w),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_w)
    );

    assign busy   = run_w;
    assign fields = split_frame(rx_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
            frame_err <= 1'b0;
        end else begin
            res_valid <= done_w;
            if (done_w) begin
                res_chan  <= fields.chan;
                res_data  <= RES_BITS'(fields.body >> PAD);
                frame_err <= fields.lead_err;
            end
        end
    end

    a_r8_single_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !done_w |=> ($stable(res_chan) && $stable(res_data) && $stable(frame_err)));

    a_r2_strobe_with_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $rose(cs_n));

endmodule

// File: tb/sim_adc_frame_master.sv
module sim_adc_frame_master;
    localparam int DIV = 2;
    localparam int RES = 8;
    localparam int PAD = 12 - RES;
    localparam int LAT = 33 * DIV + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [11:0]    ctrl = '0;
    logic           miso;
    logic           sclk, cs_n, mosi, busy, res_valid, frame_err;
    logic [1:0]     res_chan;
    logic [RES-1:0] res_data;

    int checks = 0;
    int errors = 0;
    int idle_bad = 0;

    logic [15:0] resp_word = '0;
    logic [15:0] din_cap;
    logic [15:0] last_cap = '0;
    int          falls = 0;
    int          cs_fall_cnt = 0;

    always #10 clk = ~clk;

    adc_frame_master #(.HALF_DIV(DIV), .RES_BITS(RES)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctrl_word (ctrl),
        .miso      (miso),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .busy      (busy),
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .frame_err (frame_err)
    );

    // converter model: first bit on select, next bits after each falling edge
    initial begin
        miso = 1'b0;
        din_cap = '0;
        forever begin
            @(negedge cs_n);
            cs_fall_cnt++;
            falls = 0;
            din_cap = '0;
            miso = resp_word[15];
            while (cs_n == 1'b0) begin
                @(negedge sclk or posedge cs_n);
                if (cs_n == 1'b1) break;
                if (falls < 16) din_cap[15 - falls] = mosi;
                falls++;
                #1;
                miso = (falls < 16) ? resp_word[15 - falls] : 1'b0;
            end
            last_cap = din_cap;
        end
    end

    always @(negedge clk) begin
        if (!rst && cs_n && !sclk) idle_bad++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_frame(input logic [11:0] cw, input logic [15:0] rw, output int lat);
        resp_word = rw;
        ctrl = cw;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 1;
        while (!res_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int lat;
        int hi;
        int cnt0;
        logic [RES-1:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b1, "R1 sclk", int'(sclk), 1);
        chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
        chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);

        // full sweep: every result on every channel, padding toggled (R2 R3 R4 R5 R6 R7 R8)
        for (int ch = 0; ch < 4; ch++) begin
            for (int v = 0; v < (1 << RES); v++) begin
                logic [11:0] cw;
                logic [15:0] rw;
                int padv;
                cw = 12'((v * 37 + ch * 291) ^ ((v & 1) << 11));
                padv = (v & 1) ? ((1 << PAD) - 1) : 0;
                rw = 16'((ch << 12) | (v << PAD) | padv);
                run_frame(cw, rw, lat);
                chk(lat == LAT, "R2 latency", lat, LAT);
                chk(falls == 16, "R2 falling edges", falls, 16);
                chk(res_chan == 2'(ch), "R5 channel", int'(res_chan), ch);
                chk(res_data == RES'(v), "R6 result", int'(res_data), v);
                chk(frame_err == 1'b0, "R7 clean frame", int'(frame_err), 0);
                chk(last_cap[15:4] == cw, "R3 control word", int'(last_cap[15:4]), int'(cw));
                chk(last_cap[3:0] == 4'h0, "R3 tail zeros", int'(last_cap[3:0]), 0);
                @(negedge clk);
                chk(res_valid == 1'b0, "R8 strobe width", int'(res_valid), 0);
                wait_idle();
            end
        end

        // R7 / R4: leading bits, the first one only visible from the select edge
        run_frame(12'h123, 16'h8000 | 16'h2A50, lat);
        chk(frame_err == 1'b1, "R4 R7 first leading bit", int'(frame_err), 1);
        chk(res_chan == 2'd2, "R5 chan with error", int'(res_chan), 2);
        chk(res_data == 8'hA5, "R6 data with error", int'(res_data), 'hA5);
        wait_idle();
        run_frame(12'h456, 16'h4000 | 16'h1330, lat);
        chk(frame_err == 1'b1, "R7 second leading bit", int'(frame_err), 1);
        wait_idle();
        run_frame(12'h789, 16'hC000, lat);
        chk(frame_err == 1'b1, "R7 both leading bits", int'(frame_err), 1);
        wait_idle();
        run_frame(12'h0AB, 16'h3FF0, lat);
        chk(frame_err == 1'b0, "R7 error clears", int'(frame_err), 0);
        chk(res_data == 8'hFF, "R6 full scale", int'(res_data), 'hFF);
        wait_idle();

        // R8 hold outputs between strobes
        held = res_data;
        repeat (25) @(negedge clk);
        chk(res_data == held && res_chan == 2'd3 && frame_err == 1'b0, "R8 hold",
            int'(res_data), int'(held));

        // R9 start ignored during a frame and during the gap
        cnt0 = cs_fall_cnt;
        resp_word = 16'h1230;
        ctrl = 12'hA5C;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (15) @(negedge clk);
        ctrl = 12'h3F0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (!res_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk) start = 1'b1;
        chk(busy == 1'b1, "R9 gap busy", int'(busy), 1);
        @(negedge clk) start = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(cs_fall_cnt - cnt0 == 1, "R9 frames started", cs_fall_cnt - cnt0, 1);
        chk(cs_n == 1'b1, "R9 stays deselected", int'(cs_n), 1);
        chk(last_cap[15:4] == 12'hA5C, "R9 control word kept", int'(last_cap[15:4]), 'hA5C);

        // R10 back-to-back frames with start held
        resp_word = 16'h2C30;
        ctrl = 12'h5A5;
        @(negedge clk) start = 1'b1;
        lat = 0;
        while (!res_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        hi = 0;
        while (cs_n && hi < 2000) begin
            hi++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(hi >= 2 * DIV, "R10 deselect time", hi, 2 * DIV);
        lat = 0;
        while (!res_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        chk(res_chan == 2'd2 && res_data == 8'hC3, "R5 R6 second frame", int'(res_data), 'hC3);
        wait_idle();
        chk(idle_bad == 0, "R10 sclk idle high", idle_bad, 0);

        report();
    end

endmodule